// File: doc/BRIEF.md
# Interrupt Vector Mask and Pending Controller

This block keeps a small table of message-signalled interrupt vectors. Each vector has an address, a data word and a mask bit. A pending bit and a use count sit beside each vector. Software writes the table through a 32-bit write port. Interrupt sources raise a one-cycle request for a vector, and the block turns each accepted request into a message offered on a valid/ready output. The offered message carries the vector number and that vector's address and data.

A request on an unmasked vector is queued for sending at once. A request on a masked vector is held in the pending array. It is sent on its own once the vector becomes unmasked. Writes that flip a mask bit raise a one-cycle notification with the new state. Drivers of the vectors take and release references through a use-count port, and the pending bit is dropped when the last reference goes away. Two bulk commands are provided. One flushes only the pending array. The other also returns every use count to zero.

The output side is a two-state machine. `ST_IDLE` has nothing offered. `ST_OFFER` holds a message on the output until it is accepted. The transitions are:
- **load**: from `ST_IDLE` to `ST_OFFER` when any vector waits to be sent.
- **hold**: stay in `ST_OFFER` while ready is low.
- **chain**: stay in `ST_OFFER` and load the next message when ready is high and another vector waits.
- **drain**: from `ST_OFFER` back to `ST_IDLE` when ready is high and nothing waits.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset every vector is masked. No pending bit is set, `msg_valid` is 0 and `note_valid` is 0.
- R2: A table write selects the vector with address bits [AW-1:4] and the word with bits [3:2]: 0 is address low, 1 is address high, 2 is data, 3 is control. Bits [1:0] are ignored. Bit 0 of the control word is the mask, where 1 means masked. A write whose vector index is NV or more changes nothing. A message carries the address {high,low} and the data of its vector.
- R3: A request on an unmasked vector sets no pending bit, and a message for that vector is offered on the second clock edge after the request is sampled.
- R4: A request on a masked vector sets its pending bit and issues no message.
- R5: In every cycle, a vector that is pending and unmasked has its pending bit cleared and one message queued. This covers every table write that leaves a pending vector unmasked.
- R6: A control-word write whose mask bit differs from the current mask gives `note_valid` for one cycle after the write edge, with `note_vec` and `note_masked` set to the new state. A write that keeps the mask the same gives no notification.
- R7: While `msg_valid` is high and `msg_ready` is low, the vector, address and data hold steady. When several vectors wait to be sent, the lowest-numbered vector goes first. At most one message is accepted per cycle.
- R8: An acquire adds one to a vector's use count, stopping at the maximum. A release subtracts one. A release clears the pending bit only when the count goes from 1 to 0.
- R9: A release whose vector index is NV or more, or whose vector has a zero count, changes nothing. An acquire wins when both are given in the same cycle.
- R10: `clear_all` clears every pending bit and keeps the use counts. `free_all` clears every pending bit and zeroes every use count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | AW | Page-local byte address of the write |
| wr_data | input | 32 | Write data |
| irq_req | input | NV | One-cycle request per vector |
| acq_en | input | 1 | Acquire a reference on `use_vec` |
| rel_en | input | 1 | Release a reference on `use_vec` |
| use_vec | input | VW+1 | Vector index for acquire and release |
| clear_all | input | 1 | Clear all pending bits |
| free_all | input | 1 | Clear all pending bits and all use counts |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The message is accepted |
| msg_vec | output | VW | Vector of the offered message |
| msg_addr | output | 64 | Address of the offered message |
| msg_data | output | 32 | Data of the offered message |
| note_valid | output | 1 | Mask-change notification strobe |
| note_vec | output | VW | Vector whose mask changed |
| note_masked | output | 1 | New mask state |
| pend_o | output | NV | Pending bit array |
| mask_o | output | NV | Mask bit array |

## Verification
The assertion that a masked request becomes pending assumes that the same cycle has no release and no bulk clear, because either one may rightly wipe the bit. The bench therefore never sends a request together with those commands. The hold property assumes the consumer keeps `msg_ready` as it is between clock edges. The bench drives every input just after the falling edge. The bench also never gives acquire and release together, so the use-count checks follow single operations.

// File: rtl/msix_vc_pkg.sv
package msix_vc_pkg;

    // Word select inside one 16-byte table entry.
    typedef enum logic [1:0] {
        FLD_ADDR_LO = 2'd0,
        FLD_ADDR_HI = 2'd1,
        FLD_DATA    = 2'd2,
        FLD_CTRL    = 2'd3
    } fld_e;

    // Output state machine.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } msg_st_e;

    typedef struct packed {
        logic [31:0] addr_hi;
        logic [31:0] addr_lo;
        logic [31:0] data;
    } msg_ent_t;

endpackage

// File: rtl/msix_vt_table.sv
module msix_vt_table
    import msix_vc_pkg::*;
#(
    parameter int NV = 8,
    parameter int AW = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [31:0]            wr_data,
    output msg_ent_t [NV-1:0]      ent_o,
    output logic [NV-1:0]          mask_o,
    output logic                   note_valid,
    output logic [$clog2(NV)-1:0]  note_vec,
    output logic                   note_masked
);
    localparam int VW = $clog2(NV);
    localparam int IW = AW - 4;

    logic [IW-1:0] w_idx;
    fld_e          w_fld;
    logic          w_hit;
    logic          unused_lsb;

    assign w_idx      = wr_addr[AW-1:4];
    assign w_fld      = fld_e'(wr_addr[3:2]);
    assign w_hit      = wr_en && (w_idx < IW'(NV));
    assign unused_lsb = ^wr_addr[1:0];

    for (genvar g = 0; g < NV; g++) begin : g_ent
        logic sel;
        assign sel = w_hit && (w_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_o[g]  <= '0;
                mask_o[g] <= 1'b1;
            end else if (sel) begin
                unique case (w_fld)
                    FLD_ADDR_LO: ent_o[g].addr_lo <= wr_data;
                    FLD_ADDR_HI: ent_o[g].addr_hi <= wr_data;
                    FLD_DATA:    ent_o[g].data    <= wr_data;
                    FLD_CTRL:    mask_o[g]        <= wr_data[0];
                endcase
            end
        end
    end

    // A notification is raised only when the mask actually flips.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            note_valid  <= 1'b0;
            note_vec    <= '0;
            note_masked <= 1'b0;
        end else begin
            note_valid <= 1'b0;
            if (w_hit && (w_fld == FLD_CTRL) && (wr_data[0] != mask_o[w_idx[VW-1:0]])) begin
                note_valid  <= 1'b1;
                note_vec    <= w_idx[VW-1:0];
                note_masked <= wr_data[0];
            end
        end
    end
endmodule

// File: rtl/msix_usecnt.sv
module msix_usecnt #(
    parameter int NV = 8,
    parameter int CW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acq_en,
    input  logic                  rel_en,
    input  logic [$clog2(NV):0]   use_vec,
    input  logic                  free_all,
    output logic [NV-1:0]         rel_clr_o
);
    localparam int VIW = $clog2(NV) + 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    for (genvar g = 0; g < NV; g++) begin : g_cnt
        logic [CW-1:0] cnt;
        logic          hit;
        logic          do_acq;
        logic          do_rel;

        assign hit    = (use_vec == VIW'(g));
        assign do_acq = acq_en && hit && (cnt != CMAX);
        assign do_rel = rel_en && !acq_en && hit && (cnt != '0);
        assign rel_clr_o[g] = do_rel && (cnt == CW'(1));

        always_ff @(posedge clk) begin
            if (!rst_n || free_all) begin
                cnt <= '0;
            end else if (do_acq) begin
                cnt <= cnt + CW'(1);
            end else if (do_rel) begin
                cnt <= cnt - CW'(1);
            end
        end
    end
endmodule

// File: rtl/msix_pend.sv
module msix_pend #(
    parameter int NV = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NV-1:0] irq_req,
    input  logic [NV-1:0] mask,
    input  logic [NV-1:0] rel_clr,
    input  logic          flush,
    input  logic [NV-1:0] take,
    output logic [NV-1:0] pend_o,
    output logic [NV-1:0] send_o
);
    logic [NV-1:0] drain;
    logic [NV-1:0] pend_nx;
    logic [NV-1:0] send_nx;

    always_comb begin
        drain   = pend_o & ~mask;
        pend_nx = flush ? '0 : (((pend_o & ~drain) | (irq_req & mask)) & ~rel_clr);
        send_nx = (send_o & ~take) | (irq_req & ~mask) | drain;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= '0;
            send_o <= '0;
        end else begin
            pend_o <= pend_nx;
            send_o <= send_nx;
        end
    end
endmodule

// File: rtl/msix_msg_fsm.sv
module msix_msg_fsm
    import msix_vc_pkg::*;
#(
    parameter int NV = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NV-1:0]         send_i,
    input  msg_ent_t [NV-1:0]     ent_i,
    input  logic                  msg_ready,
    output logic [NV-1:0]         take_o,
    output logic                  msg_valid,
    output logic [$clog2(NV)-1:0] msg_vec,
    output logic [63:0]           msg_addr,
    output logic [31:0]           msg_data
);
    localparam int VW = $clog2(NV);

    msg_st_e       st;
    msg_st_e       st_nx;
    logic [VW-1:0] pick;
    logic          any;
    logic          load;

    always_comb begin
        pick = '0;
        for (int i = NV - 1; i >= 0; i--) begin
            if (send_i[i]) pick = VW'(i);
        end
    end

    assign any    = |send_i;
    assign load   = any && ((st == ST_IDLE) || ((st == ST_OFFER) && msg_ready));
    assign take_o = load ? (NV'(1) << pick) : '0;

    always_comb begin
        unique case (st)
            ST_IDLE:  st_nx = any ? ST_OFFER : ST_IDLE;
            ST_OFFER: st_nx = msg_ready ? (any ? ST_OFFER : ST_IDLE) : ST_OFFER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        msg_valid = (st == ST_OFFER);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_vec  <= '0;
            msg_addr <= '0;
            msg_data <= '0;
        end else if (load) begin
            msg_vec  <= pick;
            msg_addr <= {ent_i[pick].addr_hi, ent_i[pick].addr_lo};
            msg_data <= ent_i[pick].data;
        end
    end
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
    import msix_vc_pkg::*;
#(
    parameter int NV = 8,
    parameter int AW = 12,
    parameter int CW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [NV-1:0]         irq_req,
    input  logic                  acq_en,
    input  logic                  rel_en,
    input  logic [$clog2(NV):0]   use_vec,
    input  logic                  clear_all,
    input  logic                  free_all,
    output logic                  msg_valid,
    input  logic                  msg_ready,
    output logic [$clog2(NV)-1:0] msg_vec,
    output logic [63:0]           msg_addr,
    output logic [31:0]           msg_data,
    output logic                  note_valid,
    output logic [$clog2(NV)-1:0] note_vec,
    output logic                  note_masked,
    output logic [NV-1:0]         pend_o,
    output logic [NV-1:0]         mask_o
);
    msg_ent_t [NV-1:0] ent;
    logic [NV-1:0]     rel_clr;
    logic [NV-1:0]     send;
    logic [NV-1:0]     take;

    msix_vt_table #(.NV(NV), .AW(AW)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ent_o(ent), .mask_o(mask_o), .note_valid(note_valid), .note_vec(note_vec),
        .note_masked(note_masked)
    );

    msix_usecnt #(.NV(NV), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .rel_en(rel_en), .use_vec(use_vec),
        .free_all(free_all), .rel_clr_o(rel_clr)
    );

    msix_pend #(.NV(NV)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask(mask_o), .rel_clr(rel_clr),
        .flush(clear_all || free_all), .take(take), .pend_o(pend_o), .send_o(send)
    );

    msix_msg_fsm #(.NV(NV)) u_fsm (
        .clk(clk), .rst_n(rst_n), .send_i(send), .ent_i(ent), .msg_ready(msg_ready),
        .take_o(take), .msg_valid(msg_valid), .msg_vec(msg_vec), .msg_addr(msg_addr),
        .msg_data(msg_data)
    );
endmodule

// File: rtl/msix_vec_ctrl_chk.sv
module msix_vec_ctrl_chk #(
    parameter int NV = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NV-1:0]         irq_req,
    input logic                  rel_en,
    input logic                  clear_all,
    input logic                  free_all,
    input logic                  msg_valid,
    input logic                  msg_ready,
    input logic [$clog2(NV)-1:0] msg_vec,
    input logic [63:0]           msg_addr,
    input logic [31:0]           msg_data,
    input logic                  note_valid,
    input logic [$clog2(NV)-1:0] note_vec,
    input logic                  note_masked,
    input logic [NV-1:0]         pend_o,
    input logic [NV-1:0]         mask_o
);
    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vec) && $stable(msg_addr) && $stable(msg_data))); // R7

    AST_NOTE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid |-> (mask_o[note_vec] == note_masked)); // R6

    AST_BULK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_all || free_all) |=> (pend_o == '0)); // R10

    for (genvar g = 0; g < NV; g++) begin : g_vec
        AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[g] && !mask_o[g]) |=> !pend_o[g]); // R5

        AST_MASKED_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[g] && mask_o[g] && !rel_en && !clear_all && !free_all) |=> pend_o[g]); // R4

        AST_OPEN_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[g] && !mask_o[g] && !pend_o[g]) |=> !pend_o[g]); // R3
    end
endmodule

bind msix_vec_ctrl msix_vec_ctrl_chk #(.NV(NV)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .rel_en(rel_en), .clear_all(clear_all),
    .free_all(free_all), .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vec(msg_vec),
    .msg_addr(msg_addr), .msg_data(msg_data), .note_valid(note_valid), .note_vec(note_vec),
    .note_masked(note_masked), .pend_o(pend_o), .mask_o(mask_o)
);

// File: tb/sim_msix_vec_ctrl.sv
module sim_msix_vec_ctrl;
    localparam int NV  = 8;
    localparam int AW  = 12;
    localparam int CW  = 4;
    localparam int VW  = 3;
    localparam int VIW = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           wr_en;
    logic [AW-1:0]  wr_addr;
    logic [31:0]    wr_data;
    logic [NV-1:0]  irq_req;
    logic           acq_en, rel_en;
    logic [VIW-1:0] use_vec;
    logic           clear_all, free_all;
    logic           msg_valid, msg_ready;
    logic [VW-1:0]  msg_vec;
    logic [63:0]    msg_addr;
    logic [31:0]    msg_data;
    logic           note_valid;
    logic [VW-1:0]  note_vec;
    logic           note_masked;
    logic [NV-1:0]  pend_o, mask_o;

    always #10 clk = ~clk;

    msix_vec_ctrl #(.NV(NV), .AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_req(irq_req), .acq_en(acq_en), .rel_en(rel_en), .use_vec(use_vec),
        .clear_all(clear_all), .free_all(free_all), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vec(msg_vec), .msg_addr(msg_addr), .msg_data(msg_data),
        .note_valid(note_valid), .note_vec(note_vec), .note_masked(note_masked),
        .pend_o(pend_o), .mask_o(mask_o)
    );

    typedef struct packed {
        logic [VW-1:0] v;
        logic [31:0]   hi;
        logic [31:0]   lo;
        logic [31:0]   d;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] m_lo[NV];
    logic [31:0] m_hi[NV];
    logic [31:0] m_d[NV];
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_msg(input int v);
        exp_t e;
        e.v  = VW'(v);
        e.hi = m_hi[v];
        e.lo = m_lo[v];
        e.d  = m_d[v];
        exp_q.push_back(e);
    endtask

    task automatic wr_raw(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_word(input int v, input int f, input logic [31:0] d);
        if (f == 0) m_lo[v] = d;
        if (f == 1) m_hi[v] = d;
        if (f == 2) m_d[v]  = d;
        wr_raw(AW'(v * 16 + f * 4), d);
    endtask

    task automatic pulse_irq(input logic [NV-1:0] m);
        @(negedge clk);
        irq_req = m;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic use_op(input bit acq, input int v);
        @(negedge clk);
        use_vec = VIW'(v);
        acq_en = acq;
        rel_en = !acq;
        @(negedge clk);
        acq_en = 1'b0;
        rel_en = 1'b0;
    endtask

    task automatic bulk(input bit freeing);
        @(negedge clk);
        clear_all = !freeing;
        free_all = freeing;
        @(negedge clk);
        clear_all = 1'b0;
        free_all = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on each accepted message.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #5;
            if (msg_valid && msg_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected message", 128'(msg_vec), 128'(0));
                end else begin
                    e = exp_q.pop_front();
                    chk({msg_vec, msg_addr, msg_data} == {e.v, e.hi, e.lo, e.d},
                        "R7 R2 message order and content",
                        128'({msg_vec, msg_addr, msg_data}), 128'({e.v, e.hi, e.lo, e.d}));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; irq_req = '0;
        acq_en = 1'b0; rel_en = 1'b0; use_vec = '0; clear_all = 1'b0; free_all = 1'b0;
        msg_ready = 1'b1;
        for (int i = 0; i < NV; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_d[i] = '0;
        end
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        chk(mask_o == '1, "R1 mask after reset", 128'(mask_o), 128'(8'hFF));
        chk(pend_o == '0, "R1 pending after reset", 128'(pend_o), 128'(0));
        chk(!msg_valid && !note_valid, "R1 outputs idle after reset",
            128'({msg_valid, note_valid}), 128'(0));

        // Program vectors 0..3; control writes keep them masked.
        for (int v = 0; v < 4; v++) begin
            write_word(v, 0, 32'hFEE0_0000 + 32'(v * 16));
            write_word(v, 1, 32'h0000_0100 + 32'(v));
            write_word(v, 2, 32'h0000_00D0 + 32'(v));
            write_word(v, 3, 32'h1);
            chk(!note_valid, "R6 no note for unchanged mask", 128'(note_valid), 128'(0));
        end
        // R2: byte-offset bits ignored, data word of vector 3 rewritten.
        m_d[3] = 32'hCAFE_0003;
        wr_raw(AW'(3 * 16 + 8 + 1), 32'hCAFE_0003);

        // R6: unmask vector 0 gives a notification.
        write_word(0, 3, 32'h0);
        chk(note_valid && note_vec == 0 && !note_masked, "R6 unmask note",
            128'({note_valid, note_vec, note_masked}), 128'({1'b1, 3'd0, 1'b0}));
        chk(mask_o == 8'hFE, "R2 mask bit written", 128'(mask_o), 128'(8'hFE));

        // R3: request on unmasked vector.
        expect_msg(0);
        pulse_irq(8'h01);
        chk(pend_o == '0, "R3 no pending on unmasked", 128'(pend_o), 128'(0));
        idle(4);
        chk(exp_q.size() == 0, "R3 message delivered", 128'(exp_q.size()), 128'(0));

        // R4: request on masked vector 1.
        pulse_irq(8'h02);
        idle(3);
        chk(pend_o == 8'h02, "R4 pending latched", 128'(pend_o), 128'(8'h02));

        // R5: unmasking delivers the pending request.
        expect_msg(1);
        write_word(1, 3, 32'h0);
        idle(4);
        chk(pend_o == '0, "R5 pending cleared on unmask", 128'(pend_o), 128'(0));
        chk(exp_q.size() == 0, "R5 pending message sent", 128'(exp_q.size()), 128'(0));

        // R7: priority and hold under back-pressure.
        write_word(2, 3, 32'h0);
        write_word(3, 3, 32'h0);
        @(negedge clk);
        msg_ready = 1'b0;
        expect_msg(0);
        expect_msg(2);
        expect_msg(3);
        pulse_irq(8'h0D);
        idle(3);
        chk(msg_valid && msg_vec == 0, "R7 lowest vector held",
            128'({msg_valid, msg_vec}), 128'({1'b1, 3'd0}));
        idle(2);
        chk(msg_valid && msg_vec == 0 && msg_data == m_d[0], "R7 stable while stalled",
            128'({msg_vec, msg_data}), 128'({3'd0, m_d[0]}));
        msg_ready = 1'b1;
        idle(6);
        chk(exp_q.size() == 0, "R7 all queued messages sent", 128'(exp_q.size()), 128'(0));

        // R8: release clears pending only on the last reference.
        write_word(2, 3, 32'h1);
        use_op(1'b1, 2);
        use_op(1'b1, 2);
        pulse_irq(8'h04);
        use_op(1'b0, 2);
        chk(pend_o[2], "R8 pending kept with refs left", 128'(pend_o), 128'(8'h04));
        use_op(1'b0, 2);
        chk(!pend_o[2], "R8 pending cleared on last release", 128'(pend_o), 128'(0));

        // R9: zero-count and out-of-range releases are ignored.
        pulse_irq(8'h04);
        use_op(1'b0, 2);
        chk(pend_o[2], "R9 release at zero count ignored", 128'(pend_o), 128'(8'h04));
        use_op(1'b0, NV);
        chk(pend_o[2], "R9 out-of-range release ignored", 128'(pend_o), 128'(8'h04));

        // R10: clear_all keeps counts.
        use_op(1'b1, 2);
        write_word(1, 3, 32'h1);
        pulse_irq(8'h02);
        chk(pend_o == 8'h06, "R4 two pending", 128'(pend_o), 128'(8'h06));
        bulk(1'b0);
        chk(pend_o == '0, "R10 clear_all flushes pending", 128'(pend_o), 128'(0));
        pulse_irq(8'h04);
        use_op(1'b0, 2);
        chk(!pend_o[2], "R10 count kept across clear_all", 128'(pend_o), 128'(0));

        // R10: free_all zeroes counts.
        use_op(1'b1, 2);
        pulse_irq(8'h04);
        bulk(1'b1);
        chk(pend_o == '0, "R10 free_all flushes pending", 128'(pend_o), 128'(0));
        pulse_irq(8'h04);
        use_op(1'b0, 2);
        chk(pend_o[2], "R10 count zeroed by free_all", 128'(pend_o), 128'(8'h04));
        bulk(1'b0);

        // R2: write to a vector index beyond the table changes nothing.
        wr_raw(AW'(NV * 16 + 12), 32'h0);
        chk(!note_valid && mask_o == 8'hF6, "R2 out-of-range write ignored",
            128'({note_valid, mask_o}), 128'({1'b0, 8'hF6}));

        idle(4);
        chk(exp_q.size() == 0 && !msg_valid, "R3 no stray messages",
            128'(exp_q.size()), 128'(0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule